// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-word SPI master that sits behind a plain 32-bit register bus with address, write strobe, write data, read strobe and read data. Software sets the clock polarity, clock phase and word width, picks one of eight active-low device selects, then writes a word to the transmit register. That write starts one exchange of 8 or 16 bits. At the end the received word sits in the receive register and a completion flag goes up.

The serial clock does not come from an internal divider. An external prescaler supplies a one-cycle enable pulse, and each pulse moves SCK by one edge. The point at which MISO is taken can be delayed by 0 to 3 core cycles after the nominal capture edge. This absorbs the round-trip delay of a slow or distant device. The completion flag stays set until software writes a zero to it. Software is expected to clear the flag before it starts each word.

Top module: `spi_reg_master`

## Requirements
- R1: Registers are decoded on byte address: 0x00 control, 0x04 configuration, 0x08 transmit, 0x0C receive, 0x10 completion, 0x18 timing. Control bit 0 is the select-assert bit and bits [4:2] hold the device index. Configuration bit 5 picks 16-bit words when set, bit 11 is the clock polarity and bit 12 is the clock phase. Timing bits [7:6] hold the sample delay. Unimplemented bits and unmapped addresses read 0. Read data is 0 while the read strobe is low.
- R2: After reset, control, configuration, completion and receive read 0 and timing reads 0x40 (delay 1). All eight selects are high and SCK is low.
- R3: Select line i is low exactly when the assert bit is set and the index equals i. All other select lines stay high.
- R4: A transmit write while idle starts one exchange of 8 or 16 bits, MSB first on MOSI, made of exactly 2N SCK edges. Each edge follows one enable tick.
- R5: Whenever no exchange runs, SCK sits at the configured polarity level.
- R6: With phase 0, MISO is captured on odd-numbered SCK edges and MOSI changes on even edges. With phase 1, MISO is captured on even edges and MOSI changes on odd edges after the first.
- R7: The received word is right-aligned in the receive register. In 8-bit mode bits [31:8] read 0.
- R8: Completion bit 0 becomes 1 in the same cycle the exchange ends.
- R9: A completion-register write with bit 0 clear clears the flag. A write with bit 0 set leaves it unchanged.
- R10: MISO is sampled d core cycles after the clock edge that produces a capture SCK edge, where d is the timing delay field. Enable ticks must be at least 4 cycles apart.
- R11: A transmit write during an exchange is ignored. The exchange is not restarted and the transmit register keeps the accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational |
| tick_i | input | 1 | SCK edge enable from external prescaler |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 8 | Device selects, active low |

## Verification
Exchanges run in all four polarity and phase combinations, in both word widths, with random data. Comparing the MOSI bits taken at the bench-computed capture edges against the written word separates a wrong phase from a wrong shift order. A model device moves MISO a chosen number of cycles (the lag) after each capture edge. Pairing each lag with each sample delay shows whether the delay really moves the sample point: the word comes back intact when the delay does not exceed the lag, and shifted by one bit when it does. A transmit write injected mid-exchange checks that the edge count and the received word are unaffected. Directed sweeps cover every select index and the two completion-clear write values.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BUS_W  = 32;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_CFG   = 3'd1,
    SEL_TX    = 3'd2,
    SEL_RX    = 3'd3,
    SEL_DONE  = 3'd4,
    SEL_TIME  = 3'd6
  } reg_sel_e;

  localparam int unsigned CTL_ASSERT_BIT = 0;
  localparam int unsigned CTL_IDX_LSB    = 2;
  localparam int unsigned CFG_WIDE_BIT   = 5;
  localparam int unsigned CFG_CPOL_BIT   = 11;
  localparam int unsigned CFG_CPHA_BIT   = 12;
  localparam int unsigned TIM_DLY_LSB    = 6;
  localparam logic [1:0]  DLY_RESET      = 2'd1;
endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
  import spi_rm_pkg::*;
#(
  parameter int unsigned NCS = 8,
  parameter int unsigned DW  = 16,
  localparam int unsigned IW = $clog2(NCS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              rd_en_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DW-1:0]     rx_i,
  output logic              cs_en_o,
  output logic [IW-1:0]     cs_idx_o,
  output logic              wide_o,
  output logic              cpol_o,
  output logic              cpha_o,
  output logic [1:0]        dly_o,
  output logic              start_o
);
  logic [2:0]    sel;
  logic          hit_ctrl, hit_cfg, hit_tx, hit_done, hit_time;
  logic [DW-1:0] tx_q, rx_q;
  logic          done_q;
  logic          unused_wd;

  assign sel       = addr_i[4:2];
  assign unused_wd = ^{wdata_i, addr_i[1:0]};

  assign hit_ctrl = wr_en_i && (sel == SEL_CTRL);
  assign hit_cfg  = wr_en_i && (sel == SEL_CFG);
  assign hit_tx   = wr_en_i && (sel == SEL_TX);
  assign hit_done = wr_en_i && (sel == SEL_DONE);
  assign hit_time = wr_en_i && (sel == SEL_TIME);
  assign start_o  = hit_tx && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_en_o  <= 1'b0;
      cs_idx_o <= '0;
    end else if (hit_ctrl) begin
      cs_en_o  <= wdata_i[CTL_ASSERT_BIT];
      cs_idx_o <= wdata_i[CTL_IDX_LSB +: IW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_o <= 1'b0;
      cpol_o <= 1'b0;
      cpha_o <= 1'b0;
    end else if (hit_cfg) begin
      wide_o <= wdata_i[CFG_WIDE_BIT];
      cpol_o <= wdata_i[CFG_CPOL_BIT];
      cpha_o <= wdata_i[CFG_CPHA_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dly_o <= DLY_RESET;
    else if (hit_time) dly_o <= wdata_i[TIM_DLY_LSB +: 2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_q <= '0;
    else if (start_o) tx_q <= wdata_i[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (done_i) rx_q <= rx_i;
      if (done_i)                       done_q <= 1'b1;
      else if (hit_done && !wdata_i[0]) done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (sel)
        SEL_CTRL: begin
          rdata_o[CTL_ASSERT_BIT]     = cs_en_o;
          rdata_o[CTL_IDX_LSB +: IW]  = cs_idx_o;
        end
        SEL_CFG: begin
          rdata_o[CFG_WIDE_BIT] = wide_o;
          rdata_o[CFG_CPOL_BIT] = cpol_o;
          rdata_o[CFG_CPHA_BIT] = cpha_o;
        end
        SEL_TX:   rdata_o[DW-1:0] = tx_q;
        SEL_RX:   rdata_o[DW-1:0] = rx_q;
        SEL_DONE: rdata_o[0] = done_q;
        SEL_TIME: rdata_o[TIM_DLY_LSB +: 2] = dly_o;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_rm_csdec.sv
module spi_rm_csdec #(
  parameter int unsigned NCS = 8,
  localparam int unsigned IW = $clog2(NCS)
) (
  input  logic          en_i,
  input  logic [IW-1:0] idx_i,
  output logic [NCS-1:0] cs_no
);
  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_no[i] = !(en_i && (idx_i == IW'(i)));
  end
endmodule

// File: rtl/spi_rm_engine.sv
module spi_rm_engine #(
  parameter int unsigned DW = 16,
  localparam int unsigned HW = DW / 2,
  localparam int unsigned CW = $clog2(2 * DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] tx_i,
  input  logic          wide_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic [1:0]    dly_i,
  input  logic          tick_i,
  input  logic          miso_i,
  output logic          sck_o,
  output logic          mosi_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o
);
  logic          busy_q, tog_q, cpol_q, cpha_q, wide_q, pend_q;
  logic [1:0]    dly_q, dcnt_q;
  logic [CW-1:0] edge_q, edge_nx, total;
  logic [DW-1:0] tx_sh, rx_sh;
  logic          ev, capture, shift, sample;

  assign total   = wide_q ? CW'(2 * DW) : CW'(2 * HW);
  assign edge_nx = edge_q + CW'(1);
  assign ev      = busy_q && tick_i && (edge_q != total);
  // phase 0 captures on odd edges, phase 1 on even edges
  assign capture = ev && (edge_nx[0] != cpha_q);
  assign shift   = ev && !capture && (edge_nx != total) && (edge_nx != CW'(1));
  assign sample  = (capture && dly_q == 2'd0) || (pend_q && dcnt_q == 2'd1);
  assign done_o  = busy_q && (edge_q == total) && !pend_q;

  assign sck_o  = busy_q ? (cpol_q ^ tog_q) : cpol_i;
  assign mosi_o = tx_sh[DW-1];
  assign busy_o = busy_q;
  assign rx_o   = rx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
      edge_q <= '0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      wide_q <= 1'b0;
      dly_q  <= 2'd0;
      tx_sh  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      tog_q  <= 1'b0;
      edge_q <= '0;
      cpol_q <= cpol_i;
      cpha_q <= cpha_i;
      wide_q <= wide_i;
      dly_q  <= dly_i;
      tx_sh  <= wide_i ? tx_i : {tx_i[HW-1:0], {HW{1'b0}}};
    end else begin
      if (ev) begin
        tog_q  <= !tog_q;
        edge_q <= edge_nx;
      end
      if (shift) tx_sh <= {tx_sh[DW-2:0], 1'b0};
      if (done_o) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dcnt_q <= 2'd0;
      rx_sh  <= '0;
    end else if (start_i && !busy_q) begin
      pend_q <= 1'b0;
      dcnt_q <= 2'd0;
      rx_sh  <= '0;
    end else begin
      if (capture && dly_q != 2'd0) begin
        pend_q <= 1'b1;
        dcnt_q <= dly_q;
      end else if (pend_q) begin
        dcnt_q <= dcnt_q - 2'd1;
        if (dcnt_q == 2'd1) pend_q <= 1'b0;
      end
      if (sample) rx_sh <= {rx_sh[DW-2:0], miso_i};
    end
  end
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_rm_pkg::*;
#(
  parameter int unsigned NCS = 8,
  parameter int unsigned DW  = 16,
  localparam int unsigned IW = $clog2(NCS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              rd_en_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              tick_i,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NCS-1:0]    cs_no
);
  logic          busy, done, start;
  logic          cs_en, cfg_wide, cfg_cpol, cfg_cpha;
  logic [IW-1:0] cs_idx;
  logic [1:0]    dly;
  logic [DW-1:0] rx_word;

  spi_rm_regs #(.NCS(NCS), .DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i),
    .rd_en_i  (rd_en_i),
    .rdata_o  (rdata_o),
    .busy_i   (busy),
    .done_i   (done),
    .rx_i     (rx_word),
    .cs_en_o  (cs_en),
    .cs_idx_o (cs_idx),
    .wide_o   (cfg_wide),
    .cpol_o   (cfg_cpol),
    .cpha_o   (cfg_cpha),
    .dly_o    (dly),
    .start_o  (start)
  );

  spi_rm_csdec #(.NCS(NCS)) u_csdec (
    .en_i  (cs_en),
    .idx_i (cs_idx),
    .cs_no (cs_no)
  );

  spi_rm_engine #(.DW(DW)) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .tx_i    (wdata_i[DW-1:0]),
    .wide_i  (cfg_wide),
    .cpol_i  (cfg_cpol),
    .cpha_i  (cfg_cpha),
    .dly_i   (dly),
    .tick_i  (tick_i),
    .miso_i  (miso_i),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .busy_o  (busy),
    .done_o  (done),
    .rx_o    (rx_word)
  );
endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk
  import spi_rm_pkg::*;
#(
  parameter int unsigned NCS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic              tick_i,
  input logic              sck_o,
  input logic              mosi_o,
  input logic [NCS-1:0]    cs_no,
  input logic              busy,
  input logic              cfg_cpol,
  input logic              cs_en
);
  a_r3_single_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1);

  a_r3_none_unasserted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_en |-> (&cs_no));

  a_r5_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (sck_o == cfg_cpol));

  a_r4_edge_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && !$stable(sck_o)) |-> $past(tick_i));

  a_r6_mosi_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && $stable(sck_o)) |-> $stable(mosi_o));

  a_r8_flag_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && rd_en_i && addr_i[4:2] == SEL_DONE) |-> rdata_o[0]);

  a_r11_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_en_i && addr_i[4:2] == SEL_TX && !tick_i) |=> (busy && $stable(sck_o)));
endmodule

bind spi_reg_master spi_reg_master_chk #(.NCS(NCS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .rdata_o  (rdata_o),
  .tick_i   (tick_i),
  .sck_o    (sck_o),
  .mosi_o   (mosi_o),
  .cs_no    (cs_no),
  .busy     (busy),
  .cfg_cpol (cfg_cpol),
  .cs_en    (cs_en)
);

// File: tb/spi_reg_master_tb_top.sv
module spi_reg_master_tb_top;
  localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_TX = 5'h08,
                         A_RX = 5'h0C, A_DONE = 5'h10, A_GAP = 5'h14, A_TIME = 5'h18;
  localparam int TICK_GAP = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0, miso = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, mosi;
  logic [7:0]  cs_n;
  int          n_chk = 0, n_fail = 0;
  bit          fin = 0;

  always #5 clk = ~clk;

  spi_reg_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .tick_i(tick), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n)
  );

  initial forever begin
    repeat (TICK_GAP - 1) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  function automatic logic bit_of(logic [15:0] w, int n, int k);
    return (k < n) ? w[n-1-k] : 1'b0;
  endfunction

  function automatic logic [31:0] exp_rx(logic [15:0] w, int n, int dly, int lag);
    logic [15:0] m = (n == 16) ? 16'hFFFF : 16'h00FF;
    return (dly <= lag) ? {16'h0, w & m} : {16'h0, (w << 1) & m};
  endfunction

  task automatic xfer(bit wide, bit cpol, bit cpha, int dly, int lag,
                      logic [15:0] txw, logic [15:0] mw_in, bit poke);
    int n = wide ? 16 : 8;
    logic [15:0] m = wide ? 16'hFFFF : 16'h00FF;
    logic [15:0] mw = '0;
    logic [31:0] d;
    logic prev, s;
    int edges = 0, capn = 0, cnt = 0;
    bit got = 0, poked = 0;
    wr(A_CFG, (32'(cpha) << 12) | (32'(cpol) << 11) | (32'(wide) << 5));
    wr(A_TIME, 32'(dly) << 6);
    wr(A_DONE, 32'h0);
    check("R5", "idle sck", {31'h0, sck}, {31'h0, cpol});
    miso = bit_of(mw_in, n, 0);
    @(negedge clk);
    addr = A_TX; wdata = {16'h0, txw}; wr_en = 1'b1;
    prev = sck;
    for (int cyc = 0; cyc < 4000 && !got; cyc++) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      s = sck;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) miso = bit_of(mw_in, n, capn);
      end
      if (s !== prev) begin
        edges++;
        prev = s;
        if (((edges % 2) == 1) != cpha) begin
          mw = {mw[14:0], mosi};
          capn++;
          if (lag == 0) miso = bit_of(mw_in, n, capn);
          else cnt = lag;
        end
      end
      if (poke && edges == 3 && !poked) begin
        addr = A_TX; wdata = {16'h0, ~txw}; wr_en = 1'b1; poked = 1;
      end else begin
        addr = A_DONE; rd_en = 1'b1;
        #1 if (rdata[0]) got = 1;
      end
    end
    rd_en = 1'b0;
    check("R8", "completion flag", {31'h0, got}, 32'h1);
    check("R4", "sck edge count", 32'(edges), 32'(2 * n));
    check("R6", "mosi word at capture edges", {16'h0, mw & m}, {16'h0, txw & m});
    check("R5", "sck back at idle", {31'h0, sck}, {31'h0, cpol});
    rd(A_RX, d);
    check(dly > lag ? "R10" : "R7", "received word", d, exp_rx(mw_in, n, dly, lag));
    rd(A_TX, d);
    check(poke ? "R11" : "R1", "tx readback", d, {16'h0, txw});
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R2", "selects at reset", {24'h0, cs_n}, 32'hFF);
    check("R2", "sck at reset", {31'h0, sck}, 32'h0);
    rst_n = 1'b1;
    rd(A_CTRL, d); check("R2", "ctrl reset", d, 32'h0);
    rd(A_CFG, d);  check("R2", "cfg reset", d, 32'h0);
    rd(A_TIME, d); check("R2", "timing reset", d, 32'h40);
    rd(A_DONE, d); check("R2", "flag reset", d, 32'h0);
    rd(A_RX, d);   check("R2", "rx reset", d, 32'h0);

    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); check("R1", "ctrl fields", d, 32'h1D);
    wr(A_CFG, 32'hFFFF_FFFF);  rd(A_CFG, d);  check("R1", "cfg fields", d, 32'h1820);
    wr(A_TIME, 32'hFFFF_FFFF); rd(A_TIME, d); check("R1", "timing field", d, 32'hC0);
    wr(A_GAP, 32'hFFFF_FFFF);  rd(A_GAP, d);  check("R1", "unmapped reads 0", d, 32'h0);
    addr = A_CFG; #1 check("R1", "no read strobe", rdata, 32'h0);
    wr(A_CFG, 32'h0);
    check("R5", "idle sck after cfg clear", {31'h0, sck}, 32'h0);

    for (int i = 0; i < 8; i++) begin
      wr(A_CTRL, (32'(i) << 2) | 32'h1);
      check("R3", "select asserted", {24'h0, cs_n}, {24'h0, ~(8'h1 << i)});
      wr(A_CTRL, 32'(i) << 2);
      check("R3", "select released", {24'h0, cs_n}, 32'hFF);
    end
    wr(A_CTRL, 32'h9);

    xfer(0, 0, 0, 1, 1, 16'h00A5, 16'h003C, 0);
    xfer(1, 1, 1, 1, 2, 16'hBEEF, 16'h1234, 0);
    xfer(0, 1, 0, 0, 0, 16'h0081, 16'h00F0, 0);
    xfer(1, 0, 1, 3, 3, 16'h8001, 16'hC003, 0);
    xfer(0, 0, 1, 2, 1, 16'h00C3, 16'h00B5, 0);
    xfer(1, 1, 0, 3, 2, 16'h5A5A, 16'hA5C3, 0);
    xfer(1, 0, 0, 1, 1, 16'h7E81, 16'h0FF0, 1);
    xfer(0, 1, 1, 1, 1, 16'h0042, 16'h0099, 1);

    rd(A_DONE, d); check("R9", "flag before clear", d, 32'h1);
    wr(A_DONE, 32'h1); rd(A_DONE, d); check("R9", "write 1 keeps flag", d, 32'h1);
    wr(A_DONE, 32'h0); rd(A_DONE, d); check("R9", "write 0 clears flag", d, 32'h0);

    for (int k = 0; k < 24; k++) begin
      xfer(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 4),
           int'($urandom % 4), 16'($urandom), 16'($urandom), 1'($urandom % 4 == 0));
    end

    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule